// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a small synchronous binary counter (four bits by default) that counts up or down on the rising clock edge. An active-low load input forces the count to a preset word at once, without waiting for a clock edge. An active-low enable freezes the count when it is high.

Two outputs let several stages be chained into a wider counter:
- a wrap flag, high when the next counting step in the selected direction would wrap;
- an active-low cascade strobe, which pulses low during the low half of the clock while the wrap flag is up and the stage is enabled.

A wider counter is built in one of two ways. Each upper stage can share the clock and take its enable from the wrap flags of the stages below it. Otherwise, each upper stage is clocked by the strobe of the stage below it.

Top module: `updn_counter_stage`

## Requirements
- R1: When `rst` is high at a rising clock edge and `load_n` is high, `count` becomes 0 after that edge.
- R2: While `load_n` is low, `count` equals `preset_val` with no clock edge needed, and neither counting nor `rst` changes it. After `load_n` rises, `count` keeps the preset value until the next counting edge. `preset_val` is held stable while `load_n` is low.
- R3: With `load_n` high, `rst` low, `cnt_en_n` low and `dir_down` = 0, each rising edge adds one modulo 2^WIDTH, so 15 steps to 0 when WIDTH is 4.
- R4: With `load_n` high, `rst` low, `cnt_en_n` low and `dir_down` = 1, each rising edge subtracts one modulo 2^WIDTH, so 0 steps to 15 when WIDTH is 4.
- R5: With `cnt_en_n` high, `load_n` high and `rst` low, `count` holds across rising edges.
- R6: `wrap_flag` is 1 exactly when `dir_down` = 0 and `count` is all ones, or when `dir_down` = 1 and `count` is 0. It follows a change of `dir_down` without a clock edge, and an enabled edge taken while it is high wraps the count.
- R7: `cascade_n` is 0 only while `wrap_flag` is 1, `cnt_en_n` is 0 and `clk` is low. It is 1 at all other times.
- R8: Two stages that share the clock, where the upper stage is enabled only while the lower stage's `wrap_flag` is high, form a counter of twice the width that steps through all 256 states and wraps in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counting on the rising edge, low half gates the cascade strobe |
| rst | input | 1 | Synchronous active-high clear |
| load_n | input | 1 | Active-low asynchronous preset |
| preset_val | input | WIDTH | Word loaded while `load_n` is low |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| count | output | WIDTH | Current count |
| wrap_flag | output | 1 | High at the wrap point for the selected direction |
| cascade_n | output | 1 | Active-low cascade strobe in the clock low phase |

## Verification
The preset can overlap a counting edge, and it can also overlap a synchronous clear. The bench holds `load_n` low across a rising edge, first with the enable active and then with `rst` high as well. It judges that `count` still shows the preset word after each edge. A second overlap is a direction change while the count sits at a wrap value. The bench flips `dir_down` in the clock-high phase and checks that `wrap_flag` moves before any edge occurs.

// File: rtl/updn_pkg.sv
package updn_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_UP    = 2'd1,
        OP_DOWN  = 2'd2,
        OP_CLEAR = 2'd3
    } op_e;

    typedef struct packed {
        logic all_ones;
        logic all_zeros;
    } edge_info_t;

    // Clocked operation; the preset is handled asynchronously elsewhere.
    function automatic op_e pick_op(logic clr, logic en_n, dir_e d);
        if (clr)
            return OP_CLEAR;
        if (en_n)
            return OP_HOLD;
        return (d == DIR_DOWN) ? OP_DOWN : OP_UP;
    endfunction

    function automatic logic at_wrap(dir_e d, edge_info_t e);
        return (d == DIR_UP) ? e.all_ones : e.all_zeros;
    endfunction

endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
    import updn_pkg::*;
(
    input  logic rst,
    input  logic cnt_en_n,
    input  logic dir_down,
    output op_e  op
);
    dir_e dir;

    always_comb begin
        dir = dir_e'(dir_down);
        op  = pick_op(rst, cnt_en_n, dir);
    end
endmodule

// File: rtl/updn_core.sv
module updn_core
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset_val,
    input  op_e              op,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_next;

    always_comb begin
        unique case (op)
            OP_UP:    cnt_next = cnt_q + ONE;
            OP_DOWN:  cnt_next = cnt_q - ONE;
            OP_CLEAR: cnt_next = ZERO;
            default:  cnt_next = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge load_n) begin
        if (!load_n)
            cnt_q <= preset_val;
        else
            cnt_q <= cnt_next;
    end

    // Transparent while the preset is held so the output follows at once.
    assign count = load_n ? cnt_q : preset_val;
endmodule

// File: rtl/updn_cascade.sv
module updn_cascade
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             cnt_en_n,
    input  logic             dir_down,
    input  logic [WIDTH-1:0] count,
    output logic             wrap_flag,
    output logic             cascade_n
);
    edge_info_t info;
    dir_e       dir;

    always_comb begin
        info.all_ones  = &count;
        info.all_zeros = ~|count;
        dir            = dir_e'(dir_down);
        wrap_flag      = at_wrap(dir, info);
        cascade_n      = ~(wrap_flag & ~cnt_en_n & ~clk);
    end
endmodule

// File: rtl/updn_counter_stage.sv
module updn_counter_stage
    import updn_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_n,
    input  logic [WIDTH-1:0] preset_val,
    input  logic             cnt_en_n,
    input  logic             dir_down,
    output logic [WIDTH-1:0] count,
    output logic             wrap_flag,
    output logic             cascade_n
);
    op_e op;

    updn_ctrl u_ctrl (
        .rst      (rst),
        .cnt_en_n (cnt_en_n),
        .dir_down (dir_down),
        .op       (op)
    );

    updn_core #(.WIDTH(WIDTH)) u_core (
        .clk        (clk),
        .load_n     (load_n),
        .preset_val (preset_val),
        .op         (op),
        .count      (count)
    );

    updn_cascade #(.WIDTH(WIDTH)) u_casc (
        .clk       (clk),
        .cnt_en_n  (cnt_en_n),
        .dir_down  (dir_down),
        .count     (count),
        .wrap_flag (wrap_flag),
        .cascade_n (cascade_n)
    );
endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             load_n,
    input logic [WIDTH-1:0] preset_val,
    input logic             cnt_en_n,
    input logic             dir_down,
    input logic [WIDTH-1:0] count,
    input logic             wrap_flag,
    input logic             cascade_n
);
    // R1
    clear_chk: assert property (@(posedge clk)
        (rst && load_n) |=> (!load_n || count == '0));

    // R2
    preset_chk: assert property (@(posedge clk) disable iff (rst)
        !load_n |-> count == preset_val);

    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && !$past(rst) && !$past(cnt_en_n) && !$past(dir_down))
        |-> count == WIDTH'($past(count) + 1));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && !$past(rst) && !$past(cnt_en_n) && $past(dir_down))
        |-> count == WIDTH'($past(count) - 1));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (load_n && $past(load_n) && !$past(rst) && $past(cnt_en_n))
        |-> $stable(count));

    // R6
    wrap_next_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_flag && load_n && !cnt_en_n && !dir_down)
        |=> (!load_n || rst || count == '0));

    // R7
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en_n || !wrap_flag) |-> cascade_n);
endmodule

bind updn_counter_stage updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_n     (load_n),
    .preset_val (preset_val),
    .cnt_en_n   (cnt_en_n),
    .dir_down   (dir_down),
    .count      (count),
    .wrap_flag  (wrap_flag),
    .cascade_n  (cascade_n)
);

// File: tb/updn_counter_stage_tb.sv
`timescale 1ns/1ps
module updn_counter_stage_tb;
    localparam int W = 4;
    localparam int M = 1 << W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst = 1'b1, load_n = 1'b1, en_n = 1'b1, dir = 1'b0;
    logic [W-1:0] preset = '0;
    logic [W-1:0] count;
    logic         wrap, casc_n;

    updn_counter_stage #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .preset_val(preset),
        .cnt_en_n(en_n), .dir_down(dir), .count(count),
        .wrap_flag(wrap), .cascade_n(casc_n)
    );

    // Two-stage chain, upper stage enabled by lower wrap flag
    logic         c_load_n = 1'b1, c_en_n = 1'b1, c_dir = 1'b0;
    logic [W-1:0] lo_q, hi_q;
    logic         lo_wrap, hi_wrap, lo_cn, hi_cn;

    updn_counter_stage #(.WIDTH(W)) u_lo (
        .clk(clk), .rst(rst), .load_n(c_load_n), .preset_val('0),
        .cnt_en_n(c_en_n), .dir_down(c_dir), .count(lo_q),
        .wrap_flag(lo_wrap), .cascade_n(lo_cn)
    );
    updn_counter_stage #(.WIDTH(W)) u_hi (
        .clk(clk), .rst(rst), .load_n(c_load_n), .preset_val('0),
        .cnt_en_n(c_en_n | ~lo_wrap), .dir_down(c_dir), .count(hi_q),
        .wrap_flag(hi_wrap), .cascade_n(hi_cn)
    );

    int total = 0, fails = 0;
    bit done = 1'b0;

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic low_phase();
        @(negedge clk); #0.5;
    endtask

    // Step once and check count, flag and strobe
    task automatic step_and_check(int exp, string req);
        int tcexp;
        tick();
        check(count == W'(exp), req, count, exp);
        tcexp = ((dir == 1'b0 && exp == M-1) || (dir == 1'b1 && exp == 0)) ? 1 : 0;
        check(wrap == tcexp[0], "R6", wrap, tcexp);
        low_phase();
        check(casc_n == !(tcexp[0] && !en_n), "R7", casc_n, !(tcexp[0] && !en_n));
    endtask

    task automatic do_load(int v);
        preset = W'(v); load_n = 1'b0;
        tick();
        load_n = 1'b1;
    endtask

    initial begin
        int ref_up[5];
        int ref_dn[5];
        ref_up = '{14, 15, 0, 1, 2};
        ref_dn = '{1, 0, 15, 14, 13};

        repeat (3) tick();
        // R1 reset state
        check(count == 0, "R1", count, 0);
        check(wrap == 1'b0, "R6", wrap, 0);
        check(casc_n == 1'b1, "R7", casc_n, 1);
        rst = 1'b0;

        // R6 direction flip moves the flag without an edge
        dir = 1'b1; #0.2;
        check(wrap == 1'b1, "R6", wrap, 1);
        dir = 1'b0; #0.2;
        check(wrap == 1'b0, "R6", wrap, 0);

        // R2 asynchronous preset, overrides counting and clear
        preset = 4'd13; load_n = 1'b0; #0.2;
        check(count == 13, "R2", count, 13);
        en_n = 1'b0;
        tick();
        check(count == 13, "R2", count, 13);
        rst = 1'b1;
        tick();
        check(count == 13, "R2", count, 13);
        rst = 1'b0;
        load_n = 1'b1; #0.2;
        check(count == 13, "R2", count, 13);

        // Reference sequence: up, inhibit, down (R3, R5, R4)
        foreach (ref_up[i]) step_and_check(ref_up[i], "R3");
        tick(); en_n = 1'b1;
        check(count == 3, "R3", count, 3);
        for (int i = 0; i < 4; i++) begin
            tick();
            check(count == 3, "R5", count, 3);
        end
        dir = 1'b1;
        do_load(2);
        en_n = 1'b0;
        foreach (ref_dn[i]) step_and_check(ref_dn[i], "R4");

        // Exhaustive up and down sweeps
        en_n = 1'b1; dir = 1'b0;
        do_load(0);
        en_n = 1'b0;
        for (int i = 1; i <= M; i++) step_and_check(i % M, "R3");
        dir = 1'b1;
        for (int i = 1; i <= M; i++) step_and_check((M - i) % M, "R4");

        // R7 strobe gated by enable at the wrap value
        en_n = 1'b1; dir = 1'b0;
        do_load(M - 1);
        low_phase();
        check(wrap == 1'b1, "R6", wrap, 1);
        check(casc_n == 1'b1, "R7", casc_n, 1);
        check(count == M - 1, "R5", count, M - 1);
        tick(); en_n = 1'b0;
        low_phase();
        check(casc_n == 1'b0, "R7", casc_n, 0);
        tick();
        check(casc_n == 1'b1, "R7", casc_n, 1);
        check(count == 0, "R3", count, 0);

        // R1 clear wins over counting
        en_n = 1'b0; dir = 1'b0;
        do_load(9);
        rst = 1'b1;
        tick();
        check(count == 0, "R1", count, 0);
        rst = 1'b0;

        // R8 chained 8-bit counter, both directions
        c_load_n = 1'b0;
        tick();
        c_load_n = 1'b1; c_en_n = 1'b0; c_dir = 1'b0;
        for (int i = 1; i <= 256; i++) begin
            tick();
            check({hi_q, lo_q} == 8'(i), "R8", {hi_q, lo_q}, i % 256);
        end
        c_dir = 1'b1;
        for (int i = 1; i <= 256; i++) begin
            tick();
            check({hi_q, lo_q} == 8'(256 - i), "R8", {hi_q, lo_q}, (256 - i) % 256);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule